// File: doc/BRIEF.md
# Sixteen-Bit Timer/Counter with Capture, Auto-Reload and Baud Generation

This block is a 16-bit up-counter paired with a 16-bit capture/reload register. One 8-bit control byte configures it. It runs in one of three modes. In capture mode it is a free-running timer or counter, and a falling edge on the trigger pin can freeze the current count into the capture register. In auto-reload mode an overflow, or a trigger-pin edge, loads the count from the reload register. In baud mode the count advances at half the system clock rate. Each overflow then reloads the count and sends a one-cycle tick to a serial port's bit-rate logic, and the overflow flag stays untouched.

A host reads and writes the control byte, the count and the capture register through a small address/data port. The count source is either a machine-cycle enable supplied from outside, or falling edges on the external count pin. Both external pins pass through a two-flop synchroniser before any edge is detected. The control byte holds two sticky flags: an overflow flag and an external-event flag. The interrupt request is their OR.

The mode sequencer is a state machine with states `ST_RELOAD` (reset state), `ST_CAPTURE` and `ST_BAUD`. It has these transitions:
- reload-to-baud and capture-to-baud whenever either baud-select bit is 1;
- reload-to-capture when the capture bit is set and neither baud bit is;
- capture-to-reload when the capture bit is cleared and neither baud bit is;
- baud-to-capture or baud-to-reload, picked by the capture bit, when both baud bits are cleared.

Top module: `tmr2_unit`

## Requirements
- R1: After reset the control byte, count and capture register read 0, and the overflow flag, external flag, interrupt request and baud tick are 0.
- R2: Register addresses are 0 control, 1 count low byte, 2 count high byte, 3 capture low byte, 4 capture high byte. Reads return the written value. Control bits from MSB to LSB: 7 overflow flag, 6 external flag, 5 receive-baud select, 4 transmit-baud select, 3 external-trigger enable, 2 run, 1 count-pin select, 0 capture select.
- R3: With run = 1 and count-pin select = 0, the count advances by one on each clock with the machine-cycle enable high (outside baud mode). With count-pin select = 1 it advances once per falling edge of the count pin. With run = 0 it holds.
- R4: In capture mode (capture select = 1, both baud bits 0) a count of FFFFh advances to 0000h and sets the overflow flag.
- R5: In capture mode with trigger enable = 1, a trigger-pin falling edge copies the count into the capture register and sets the external flag, and the count is unchanged. With trigger enable = 0 the edge changes neither.
- R6: In reload mode (capture select = 0, both baud bits 0) an overflow loads the count from the capture register and sets the overflow flag.
- R7: In reload mode with trigger enable = 1, a trigger-pin falling edge loads the count from the capture register and sets the external flag.
- R8: In baud mode (either baud bit 1) with count-pin select = 0, the count advances once every two clocks. An overflow reloads it from the capture register and raises the baud tick for exactly one cycle. The overflow flag is never set.
- R9: In baud mode a trigger-pin falling edge sets the external flag only when trigger enable = 1. It changes neither the count nor the capture register.
- R10: Hardware only sets the flags and a control write is the only way to clear them. The interrupt request equals overflow flag OR external flag.
- R11: A pin falling edge takes effect at the third rising clock edge after the pin changes. A control write changes the mode state at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_en | input | 1 | Machine-cycle enable, the timer count source |
| t2_pin | input | 1 | External count pin (asynchronous) |
| t2ex_pin | input | 1 | External trigger pin (asynchronous) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| tf2 | output | 1 | Overflow flag |
| exf2 | output | 1 | External-event flag |
| irq | output | 1 | Interrupt request |
| baud_tick | output | 1 | One-cycle baud-rate pulse |

## Verification
The cycle in which each result is due:
- a register write shows on the first clock edge;
- a timer overflow shows on the edge that consumes the tick;
- a pin edge shows on the third edge after the pin moves;
- the baud tick shows one cycle after the overflow edge that raised it.

The bench changes pins and writes on the falling clock edge. It then counts the exact number of rising edges before it samples in the next low phase, and for the pin path it also samples one edge early to check that the result is not yet there. Rates are measured as the difference between two count readings taken a fixed number of edges apart, after a settling interval. Because of that settling interval, the baud divider's phase does not affect the result.

// File: rtl/tmr2_pkg.sv
package tmr2_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd4;

    localparam int B_TF   = 7;
    localparam int B_EXF  = 6;
    localparam int B_RXB  = 5;
    localparam int B_TXB  = 4;
    localparam int B_EXEN = 3;
    localparam int B_RUN  = 2;
    localparam int B_PIN  = 1;
    localparam int B_CAP  = 0;

    typedef enum logic [1:0] {
        ST_RELOAD  = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_BAUD    = 2'd2
    } t2_state_e;
endpackage

// File: rtl/tmr2_pin_sync.sv
module tmr2_pin_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] fall_o
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_pin
            logic [STAGES:0] sh_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '1;
                else        sh_q <= {sh_q[STAGES-1:0], pin_i[g]};
            end
            assign fall_o[g] = sh_q[STAGES] & ~sh_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/tmr2_mode_fsm.sv
module tmr2_mode_fsm
    import tmr2_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      baud_sel,
    input  logic      cap_sel,
    output t2_state_e state_o,
    output logic      is_capture,
    output logic      is_reload,
    output logic      is_baud
);
    t2_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RELOAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RELOAD: begin
                if (baud_sel)     state_d = ST_BAUD;
                else if (cap_sel) state_d = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                if (baud_sel)      state_d = ST_BAUD;
                else if (!cap_sel) state_d = ST_RELOAD;
            end
            ST_BAUD: begin
                if (!baud_sel) state_d = cap_sel ? ST_CAPTURE : ST_RELOAD;
            end
            default: state_d = ST_RELOAD;
        endcase
    end

    always_comb begin
        is_capture = 1'b0;
        is_reload  = 1'b0;
        is_baud    = 1'b0;
        unique case (state_q)
            ST_RELOAD:  is_reload  = 1'b1;
            ST_CAPTURE: is_capture = 1'b1;
            ST_BAUD:    is_baud    = 1'b1;
            default:    is_reload  = 1'b1;
        endcase
    end

    assign state_o = state_q;

    // R11: the mode state follows a baud selection on the next edge
    p_mode_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        baud_sel |=> (state_q == ST_BAUD));
endmodule

// File: rtl/tmr2_unit.sv
module tmr2_unit
    import tmr2_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_en,
    input  logic              t2_pin,
    input  logic              t2ex_pin,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              tf2,
    output logic              exf2,
    output logic              irq,
    output logic              baud_tick
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [BYTE_W-1:0] ctrl_q, ctrl_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d, cap_q, cap_d;
    logic              div_q, tick_q;
    logic [1:0]        fall;
    logic              t2_fall, t2ex_fall;
    t2_state_e         state;
    logic              is_capture, is_reload, is_baud;

    tmr2_pin_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({t2ex_pin, t2_pin}),
        .fall_o (fall)
    );
    assign t2_fall   = fall[0];
    assign t2ex_fall = fall[1];

    logic baud_sel;
    assign baud_sel = ctrl_q[B_RXB] | ctrl_q[B_TXB];

    tmr2_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_sel   (baud_sel),
        .cap_sel    (ctrl_q[B_CAP]),
        .state_o    (state),
        .is_capture (is_capture),
        .is_reload  (is_reload),
        .is_baud    (is_baud)
    );

    logic wr_ctrl, wr_cnt_lo, wr_cnt_hi, wr_cap_lo, wr_cap_hi;
    assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
    assign wr_cnt_lo = reg_wr && (reg_addr == A_CNT_LO);
    assign wr_cnt_hi = reg_wr && (reg_addr == A_CNT_HI);
    assign wr_cap_lo = reg_wr && (reg_addr == A_CAP_LO);
    assign wr_cap_hi = reg_wr && (reg_addr == A_CAP_HI);

    logic run, ext_ev, base_tick, cnt_tick, ovf, tf_set;
    assign run       = ctrl_q[B_RUN];
    assign ext_ev    = t2ex_fall & ctrl_q[B_EXEN];
    assign base_tick = is_baud ? div_q : mc_en;
    assign cnt_tick  = run & (ctrl_q[B_PIN] ? t2_fall : base_tick);
    assign ovf       = cnt_tick & (cnt_q == CNT_MAX);
    assign tf_set    = ovf & ~is_baud & ~baud_sel;

    // count path: hardware first, host writes override
    always_comb begin
        cnt_d = cnt_q;
        if (cnt_tick) cnt_d = (ovf && !is_capture) ? cap_q : cnt_q + 1'b1;
        if (is_reload && ext_ev) cnt_d = cap_q;
        if (wr_cnt_lo) cnt_d[BYTE_W-1:0]     = reg_wdata;
        if (wr_cnt_hi) cnt_d[CNT_W-1:BYTE_W] = reg_wdata;
    end

    always_comb begin
        cap_d = cap_q;
        if (is_capture && ext_ev) cap_d = cnt_q;
        if (wr_cap_lo) cap_d[BYTE_W-1:0]     = reg_wdata;
        if (wr_cap_hi) cap_d[CNT_W-1:BYTE_W] = reg_wdata;
    end

    // control path: a hardware flag set wins over a same-cycle clear
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) ctrl_d = reg_wdata;
        if (tf_set)  ctrl_d[B_TF]  = 1'b1;
        if (ext_ev)  ctrl_d[B_EXF] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cnt_q  <= '0;
            cap_q  <= '0;
            div_q  <= 1'b0;
            tick_q <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            cnt_q  <= cnt_d;
            cap_q  <= cap_d;
            div_q  <= (is_baud && run) ? ~div_q : 1'b0;
            tick_q <= ovf & is_baud;
        end
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:   reg_rdata = ctrl_q;
            A_CNT_LO: reg_rdata = cnt_q[BYTE_W-1:0];
            A_CNT_HI: reg_rdata = cnt_q[CNT_W-1:BYTE_W];
            A_CAP_LO: reg_rdata = cap_q[BYTE_W-1:0];
            A_CAP_HI: reg_rdata = cap_q[CNT_W-1:BYTE_W];
            default:  reg_rdata = '0;
        endcase
    end

    assign tf2       = ctrl_q[B_TF];
    assign exf2      = ctrl_q[B_EXF];
    assign irq       = tf2 | exf2;
    assign baud_tick = tick_q;

    // R10: flags are sticky until a control write
    p_tf2_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tf2 && !wr_ctrl) |=> tf2);
    p_exf2_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exf2 && !wr_ctrl) |=> exf2);
    // R8: overflow flag never rises in baud state, tick lasts one cycle
    p_no_tf2_baud_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_baud && !wr_ctrl) |=> !$rose(tf2));
    p_tick_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick);
    // R3: a stopped counter holds unless written or trigger-reloaded
    p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt_lo && !wr_cnt_hi && !(is_reload && ext_ev)) |=> $stable(cnt_q));
    // R5: a capture event stores the count seen in that cycle
    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_capture && ext_ev && !wr_cap_lo && !wr_cap_hi) |=> (cap_q == $past(cnt_q)));
endmodule

// File: tb/tb_tmr2_unit.sv
module tb_tmr2_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_en = 1'b0;
    logic       t2_pin = 1'b1;
    logic       t2ex_pin = 1'b1;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       tf2, exf2, irq, baud_tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    tmr2_unit dut (
        .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .t2_pin(t2_pin), .t2ex_pin(t2ex_pin),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tf2(tf2), .exf2(exf2), .irq(irq), .baud_tick(baud_tick)
    );

    // {ctrl[31:24], mc_en[23], cycles[22:16], expected delta[15:0]}
    localparam logic [31:0] VEC [7] = '{
        32'h048A000A, 32'h008A0000, 32'h040A0000, 32'h058C000C,
        32'h140A0005, 32'h24880004, 32'h068A0000
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
        reg_addr = lo;        #1 v[7:0]  = reg_rdata;
        reg_addr = lo + 3'd1; #1 v[15:8] = reg_rdata;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr16(input logic [2:0] lo, input logic [15:0] v);
        wr(lo, v[7:0]);
        wr(lo + 3'd1, v[15:8]);
    endtask

    task automatic ex_fall;
        @(negedge clk); t2ex_pin = 1'b0;
    endtask

    task automatic ex_release;
        t2ex_pin = 1'b1; tick(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    logic [15:0] a, b;
    logic [31:0] v;
    bit seen;

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        reg_addr = 3'd0; #1 chk("R1 ctrl", {8'h0, reg_rdata}, 16'h0);
        rd16(3'd1, a); chk("R1 count", a, 16'h0);
        rd16(3'd3, a); chk("R1 capture", a, 16'h0);
        chk("R1 outputs", {12'h0, tf2, exf2, irq, baud_tick}, 16'h0);

        // R2 register map
        wr(3'd0, 8'h2A);
        reg_addr = 3'd0; #1 chk("R2 ctrl readback", {8'h0, reg_rdata}, 16'h002A);
        wr(3'd0, 8'h00);
        wr16(3'd1, 16'h1234);
        rd16(3'd1, a); chk("R2 count readback", a, 16'h1234);
        tick(2);

        // vector table: count rate per configuration
        for (int i = 0; i < 7; i++) begin
            v = VEC[i];
            mc_en = v[23];
            wr(3'd0, v[31:24]);
            tick(3);
            rd16(3'd1, a);
            tick(int'(v[22:16]));
            rd16(3'd1, b);
            chk((v[29] | v[28]) ? "R8 baud rate" : "R3 timer rate", b - a, v[15:0]);
        end

        // R4 capture-mode overflow
        mc_en = 1'b0;
        wr(3'd0, 8'h00);
        wr16(3'd1, 16'hFFFE);
        mc_en = 1'b1;
        wr(3'd0, 8'h05);
        tick(1); rd16(3'd1, a);
        chk("R4 pre-overflow count", a, 16'hFFFF);
        chk("R4 flag not yet set", {15'h0, tf2}, 16'h0);
        tick(1); rd16(3'd1, a);
        chk("R4 wrap count", a, 16'h0000);
        chk("R4 flag set", {15'h0, tf2}, 16'h1);
        // R10 sticky flag and interrupt, cleared by write
        tick(4);
        chk("R10 flag sticky", {14'h0, tf2, irq}, 16'h3);
        wr(3'd0, 8'h01);
        chk("R10 cleared by write", {14'h0, tf2, irq}, 16'h0);
        mc_en = 1'b0;

        // R5 capture on trigger
        wr(3'd0, 8'h09);
        wr16(3'd1, 16'h1234);
        ex_fall();
        tick(2);
        chk("R11 not before third edge", {15'h0, exf2}, 16'h0);
        tick(1);
        chk("R5 external flag", {14'h0, exf2, irq}, 16'h3);
        rd16(3'd3, a); chk("R5 captured value", a, 16'h1234);
        rd16(3'd1, a); chk("R5 count unchanged", a, 16'h1234);
        ex_release();
        wr(3'd0, 8'h01);
        wr16(3'd1, 16'h5555);
        ex_fall(); tick(3);
        rd16(3'd3, a); chk("R5 disabled trigger ignored", a, 16'h1234);
        chk("R5 disabled no flag", {15'h0, exf2}, 16'h0);
        ex_release();

        // R7 trigger reload
        wr(3'd0, 8'h08);
        wr16(3'd3, 16'hABCD);
        wr16(3'd1, 16'h0010);
        ex_fall(); tick(3);
        rd16(3'd1, a); chk("R7 reloaded count", a, 16'hABCD);
        chk("R7 external flag", {15'h0, exf2}, 16'h1);
        ex_release();

        // R6 overflow reload
        wr(3'd0, 8'h00);
        wr16(3'd3, 16'h8000);
        wr16(3'd1, 16'hFFFF);
        mc_en = 1'b1;
        wr(3'd0, 8'h04);
        tick(1); rd16(3'd1, a);
        chk("R6 reload on overflow", a, 16'h8000);
        chk("R6 overflow flag", {15'h0, tf2}, 16'h1);
        mc_en = 1'b0;
        wr(3'd0, 8'h00);

        // R8 baud overflow
        wr16(3'd3, 16'hF000);
        wr16(3'd1, 16'hFFFC);
        wr(3'd0, 8'h14);
        seen = 0;
        for (int k = 0; k < 40 && !seen; k++) begin
            tick(1);
            if (baud_tick) seen = 1;
        end
        chk("R8 baud tick seen", {15'h0, seen}, 16'h1);
        rd16(3'd1, a); chk("R8 baud reload", a, 16'hF000);
        chk("R8 no overflow flag", {15'h0, tf2}, 16'h0);
        tick(1);
        chk("R8 tick one cycle", {15'h0, baud_tick}, 16'h0);

        // R9 baud trigger
        wr(3'd0, 8'h18);
        wr16(3'd1, 16'h0042);
        ex_fall(); tick(3);
        chk("R9 flag with enable", {15'h0, exf2}, 16'h1);
        rd16(3'd1, a); chk("R9 count unchanged", a, 16'h0042);
        rd16(3'd3, a); chk("R9 capture unchanged", a, 16'hF000);
        ex_release();
        wr(3'd0, 8'h10);
        ex_fall(); tick(3);
        chk("R9 no flag without enable", {15'h0, exf2}, 16'h0);
        ex_release();

        // R3 external count pin
        wr(3'd0, 8'h00);
        wr16(3'd1, 16'h0000);
        wr(3'd0, 8'h06);
        for (int k = 0; k < 4; k++) begin
            t2_pin = 1'b0; tick(2);
            t2_pin = 1'b1; tick(2);
        end
        tick(3);
        rd16(3'd1, a); chk("R3 pin edge count", a, 16'h0004);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule